// File: doc/BRIEF.md
# I2C Channel-Select Slave

This block is an I2C/SMBus slave that owns one 8-bit channel-select register for an upstream bus multiplexer. SCL and SDA are oversampled with a fast system clock, synchronised and de-glitched, and the filtered lines drive a small bus engine. The engine detects start, repeated start and stop conditions, matches a 7-bit address and acknowledges it. It then either captures written bytes or shifts the register contents back out to the master.

A written selection is held pending and reaches the channel-enable outputs only when the master closes the transfer with a stop. The mux therefore never switches in the middle of a transaction. If a transfer carries several data bytes, the final one is the one applied. A start that arrives before the stop drops the pending value. The block has no data stream of its own: both outputs are plain control levels. The SDA output is an open-drain pull-down request that is never driven high.

Top module: `chsel_i2c_slave`

## Requirements
- R1: The slave answers the 7-bit address whose upper four bits are 1110 and whose lower three bits equal `addr_strap[2:0]`, with bit 2 the most significant. Address bits arrive MSB first, followed by a direction bit where 0 means write and 1 means read. A matching address is acknowledged by holding `sda_pull` high through the whole high phase of the ninth SCL pulse.
- R2: When the address does not match, `sda_pull` stays low for the address acknowledge and for every later bit until the next start or stop. Bytes sent in that time leave `chan_en` unchanged.
- R3: In a write, each received data byte is acknowledged. Bit n of the byte (bit 0 = LSB) selects channel n, and any combination of bits may be set.
- R4: `chan_en` changes only in response to a bus stop condition, or to reset. A written value is not visible on `chan_en` before the stop.
- R5: When a single write transfer carries several data bytes, only the last byte reaches `chan_en` at the stop.
- R6: In a read, the slave shifts out the register value MSB first, one bit per SCL pulse. It repeats the value for each byte the master acknowledges. After the master's not-acknowledge it releases SDA.
- R7: Driving `rst_n` low clears `chan_en` and the register to 0x00 and returns the bus engine to idle. A following read returns 0x00.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system-clock samples is ignored.
- R9: A start or repeated start that arrives after a write but before its stop discards the pending byte, and `chan_en` keeps its previous value.
- R10: SDA is only ever pulled low, through `sda_pull`. The pull-down starts only while the filtered SCL is low.
- R11: A repeated start at any point returns the slave to the address phase, and a matching address after it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset; also serves as the power-on initialisation |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| addr_strap | input | 3 | Strap value forming the low three address bits |
| sda_pull | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |
| chan_en | output | 8 | Applied channel-enable vector, one bit per downstream channel |

## Verification
Bad internal state shows at the ports within one byte time. A wrong bit counter or a stale address compare shows up as a missing or misplaced acknowledge on the ninth pulse of the very next byte. A leaky commit path shows as `chan_en` moving before the stop, or on an aborted or foreign transfer. The scoreboard catches that on the first unexpected edge. A damaged shift register or reload path corrupts the bits read back, and it does so in the first read byte or at the first re-acknowledged byte.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CH_W      = 8;
  localparam logic [3:0] ADDR_HI = 4'b1110;
  localparam int BIT_CW    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BIT,
    ST_WR_ACK,
    ST_RD_BIT,
    ST_RD_ACK,
    ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/chsel_line_filter.sv
module chsel_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      dout   <= 1'b1;
      run_q  <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      if (sync_q == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R8
  flt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(run_q) == CW'(FILT_LEN - 1));

  // R8
  flt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> dout == $past(sync_q));
endmodule

// File: rtl/chsel_bus_fsm.sv
module chsel_bus_fsm
  import chsel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl,
  input  logic            sda,
  input  logic [2:0]      addr_strap,
  output logic            sda_pull,
  output logic [CH_W-1:0] chan_en
);
  logic scl_d, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;

  bus_st_e           st;
  logic [BIT_CW-1:0] cnt;
  logic [CH_W-1:0]   shreg;
  logic [CH_W-1:0]   sel_reg;
  logic              pend;
  logic              rd_q;
  logic              mack;
  logic              addr_hit;

  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_c  = scl & scl_d & sda_d & ~sda;
  assign stop_c   = scl & scl_d & ~sda_d & sda;
  assign addr_hit = (shreg[7:1] == {ADDR_HI, addr_strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      sel_reg  <= '0;
      chan_en  <= '0;
      pend     <= 1'b0;
      rd_q     <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      st       <= ST_ADDR;
      cnt      <= '0;
      shreg    <= '0;
      pend     <= 1'b0;
      sel_reg  <= chan_en;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
      pend     <= 1'b0;
      if (pend) chan_en <= sel_reg;
    end else begin
      case (st)
        ST_ADDR, ST_WR_BIT: begin
          if (scl_rise) begin
            shreg <= {shreg[CH_W-2:0], sda};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == BIT_CW'(CH_W)) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                sda_pull <= 1'b1;
                rd_q     <= shreg[0];
                st       <= ST_ADDR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end else begin
              sel_reg  <= shreg;
              pend     <= 1'b1;
              sda_pull <= 1'b1;
              st       <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_q) begin
              shreg    <= sel_reg;
              sda_pull <= ~sel_reg[CH_W-1];
              st       <= ST_RD_BIT;
            end else begin
              sda_pull <= 1'b0;
              st       <= ST_WR_BIT;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            st       <= ST_WR_BIT;
          end
        end
        ST_RD_BIT: begin
          if (scl_fall) begin
            if (cnt == BIT_CW'(CH_W - 1)) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              st       <= ST_RD_ACK;
            end else begin
              shreg    <= {shreg[CH_W-2:0], 1'b0};
              sda_pull <= ~shreg[CH_W-2];
              cnt      <= cnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda;
          end else if (scl_fall) begin
            if (mack) begin
              shreg    <= sel_reg;
              sda_pull <= ~sel_reg[CH_W-1];
              st       <= ST_RD_BIT;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R4
  en_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_c));

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl);

  // R2
  quiet_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP || st == ST_IDLE) |-> !sda_pull);

  // R1
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && st == ST_ADDR_ACK) |-> $past(shreg[7:1]) == {ADDR_HI, addr_strap});

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !pend);
endmodule

// File: rtl/chsel_i2c_slave.sv
module chsel_i2c_slave
  import chsel_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic [2:0]      addr_strap,
  output logic            sda_pull,
  output logic [CH_W-1:0] chan_en
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_lines;
  logic [NLINE-1:0] clean_lines;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    chsel_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (clean_lines[g])
    );
  end

  chsel_bus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (clean_lines[0]),
    .sda       (clean_lines[1]),
    .addr_strap(addr_strap),
    .sda_pull  (sda_pull),
    .chan_en   (chan_en)
  );
endmodule

// File: tb/chsel_i2c_slave_test.sv
module chsel_i2c_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_pull;
  logic [7:0] chan_en;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] last_en = 8'h00;

  assign sda_bus = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  chsel_i2c_slave #(.FILT_LEN(4)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_strap(strap), .sda_pull(sda_pull), .chan_en(chan_en)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every change on chan_en is matched against the scoreboard queue (R4)
  always @(negedge clk) begin
    if (mon_on && chan_en !== last_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected enable change", chan_en, last_en);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(chan_en === e, "R4 enable update", chan_en, e);
      end
      last_en = chan_en;
    end
  end

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 3) begin
        wq(3); scl_m = 1; wq(2); scl_m = 0; wq(Q - 5);
      end else wq(Q);
      scl_m = 1;
      if (glitch && i == 2) begin
        wq(Q - 2); sda_m = 0; wq(2); sda_m = 1; wq(Q);
      end else wq(2*Q);
      scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    acked = !sda_bus;
    wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit rel_ok);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 0;
    end
    wq(Q);
    rel_ok = !sda_pull;
    sda_m = !give_ack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); sda_m = 1;
  endtask

  initial begin
    bit a;
    bit rel;
    logic [7:0] rb;
    wq(5);
    chk(chan_en === 8'h00, "R7 reset enables", chan_en, 8'h00);
    chk(sda_pull === 1'b0, "R10 reset pull", {7'd0, sda_pull}, 8'h00);
    rst_n = 1; mon_on = 1; wq(5);

    // R1 R3 R4: single write
    bus_start();
    send_byte(8'hEA, 0, a); chk(a, "R1 address ack", {7'd0, a}, 8'h01);
    send_byte(8'hA5, 0, a); chk(a, "R3 data ack", {7'd0, a}, 8'h01);
    chk(chan_en === 8'h00, "R4 held until stop", chan_en, 8'h00);
    exp_q.push_back(8'hA5);
    bus_stop();
    chk(chan_en === 8'hA5, "R3 enables applied", chan_en, 8'hA5);

    // R5: several bytes, last wins
    bus_start();
    send_byte(8'hEA, 0, a);
    send_byte(8'h11, 0, a);
    send_byte(8'h22, 0, a); chk(a, "R3 second byte ack", {7'd0, a}, 8'h01);
    send_byte(8'h81, 0, a);
    chk(chan_en === 8'hA5, "R4 multi-byte held", chan_en, 8'hA5);
    exp_q.push_back(8'h81);
    bus_stop();
    chk(chan_en === 8'h81, "R5 last byte wins", chan_en, 8'h81);

    // R6: read with ack, ack, nack
    bus_start();
    send_byte(8'hEB, 0, a); chk(a, "R6 read address ack", {7'd0, a}, 8'h01);
    recv_byte(1, rb, rel); chk(rb === 8'h81, "R6 read byte 1", rb, 8'h81);
    recv_byte(1, rb, rel); chk(rb === 8'h81, "R6 read byte 2", rb, 8'h81);
    recv_byte(0, rb, rel); chk(rb === 8'h81, "R6 read byte 3", rb, 8'h81);
    wq(Q); chk(sda_pull === 1'b0, "R6 released after nack", {7'd0, sda_pull}, 8'h00);
    bus_stop();

    // R2: foreign address
    bus_start();
    send_byte(8'hE2, 0, a); chk(!a, "R2 no ack on mismatch", {7'd0, a}, 8'h00);
    send_byte(8'hFF, 0, a); chk(!a, "R2 data ignored", {7'd0, a}, 8'h00);
    bus_stop();
    chk(chan_en === 8'h81, "R2 enables unchanged", chan_en, 8'h81);

    // R9 R11: write aborted by repeated start, then read
    bus_start();
    send_byte(8'hEA, 0, a);
    send_byte(8'h3C, 0, a);
    bus_rstart();
    send_byte(8'hEB, 0, a); chk(a, "R11 ack after repeated start", {7'd0, a}, 8'h01);
    recv_byte(0, rb, rel); chk(rb === 8'h81, "R9 aborted byte discarded", rb, 8'h81);
    bus_stop();
    chk(chan_en === 8'h81, "R9 enables unchanged", chan_en, 8'h81);

    // R8: short pulses on SCL and SDA
    bus_start();
    send_byte(8'hEA, 0, a);
    send_byte(8'h0F, 1, a); chk(a, "R8 ack despite glitches", {7'd0, a}, 8'h01);
    exp_q.push_back(8'h0F);
    bus_stop();
    chk(chan_en === 8'h0F, "R8 glitches rejected", chan_en, 8'h0F);

    // R1: other strap value
    strap = 3'b000; wq(Q);
    bus_start();
    send_byte(8'hE0, 0, a); chk(a, "R1 strap 000 ack", {7'd0, a}, 8'h01);
    send_byte(8'h80, 0, a);
    exp_q.push_back(8'h80);
    bus_stop();
    chk(chan_en === 8'h80, "R3 single channel 7", chan_en, 8'h80);

    // R7: reset mid-transfer
    bus_start();
    send_byte(8'hE0, 0, a);
    send_byte(8'h55, 0, a);
    exp_q.push_back(8'h00);
    rst_n = 0; wq(3);
    chk(chan_en === 8'h00, "R7 reset clears", chan_en, 8'h00);
    rst_n = 1; scl_m = 1; sda_m = 1; wq(Q);
    bus_start();
    send_byte(8'hE1, 0, a); chk(a, "R7 idle after reset", {7'd0, a}, 8'h01);
    recv_byte(0, rb, rel); chk(rb === 8'h00, "R7 register cleared", rb, 8'h00);
    bus_stop();

    wq(Q);
    chk(exp_q.size() == 0, "R4 all updates seen", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule